// File: doc/BRIEF.md
# Pipelined Synchronous Burst RAM

This block is a synthesizable single-clock static RAM with a two-stage read pipeline and a built-in two-bit burst sequencer. The address, write data, the three chip enables, the two burst-start strobes, the advance input and the write controls are all sampled on the rising clock edge. One start strobe serves a processor and the other a memory controller. Either strobe loads a fresh external address. After the start, the two low address bits come from an internal counter, which steps only in cycles where the advance input is asserted. A static order input selects linear or interleaved sequencing.

Writes may cover any subset of the byte lanes, and a global write covers all of them. Read data passes through an output register. It reaches the bus one edge after the edge that takes the address. An output enable acts without the clock and only decides whether the held read word drives the bus. When the device is deselected, the bus is released one edge later. A sleep input gives a low-power standby. In standby the array keeps its contents and every other input is ignored. The depth, the word width and the lane count are parameters. The defaults are a 64-word array of 36-bit words in four 9-bit lanes.

Top module: `sync_burst_ram`

## Requirements
- R1: A start cycle selects the device only when en_a_n=0, en_b=1 and en_c_n=0. A start with any of these false performs no access and ends any running burst.
- R2: When strb_ctl_n=0 and no processor start is accepted, a selected start loads `addr`. The cycle is a write if wr_all_n=0 or any bit of wr_lane_n is 0, and a read otherwise.
- R3: A processor start (strb_cpu_n=0 with en_a_n=0) takes priority over strb_ctl_n and loads `addr`. It is always a read, whatever the write controls say. A later continuation cycle may then write. When en_a_n=1, strb_cpu_n is ignored.
- R4: In a cycle with no accepted start and an active burst, the access uses the burst address. When step_n=0 the counter advances before the access. When step_n=1 the previous address is repeated. The chip enables are ignored in such cycles.
- R5: With seq_linear=1, the low two address bits are (start[1:0] + count) mod 4. The upper address bits stay at the start value.
- R6: With seq_linear=0, the low two address bits are start[1:0] XOR count. The upper address bits stay at the start value.
- R7: On a write, lane i is bits [9i+8:9i] of the word and is written when wr_lane_n[i]=0. The other lanes keep their contents. wr_all_n=0 writes all four lanes, whatever wr_lane_n holds.
- R8: A read taken at edge k drives the word onto `rdata`, with rdata_on=1, from edge k+1 until edge k+2. The word is the array contents as they stood at edge k.
- R9: After a write, a deselecting start or an idle cycle taken at edge k, rdata_on is 0 after edge k+1.
- R10: out_en_n=1 forces rdata_on to 0 at once, without waiting for a clock edge. Returning it to 0 shows the same held word again.
- R11: While sleep=1, rdata_on is 0, no write happens and strobes are ignored. Any running burst ends. The array contents are kept through standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| sleep | input | 1 | Low-power standby, active high |
| en_a_n | input | 1 | Primary chip enable, active low |
| en_b | input | 1 | Secondary chip enable, active high |
| en_c_n | input | 1 | Secondary chip enable, active low |
| strb_cpu_n | input | 1 | Processor burst-start strobe, active low |
| strb_ctl_n | input | 1 | Controller burst-start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| seq_linear | input | 1 | 1 selects linear order, 0 selects interleaved order |
| wr_all_n | input | 1 | Global write, active low |
| wr_lane_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | External word address |
| wdata | input | DATA_W | Write data |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| rdata | output | DATA_W | Read data, high impedance when not driven |
| rdata_on | output | 1 | 1 while `rdata` is driven |

## Verification
Several internal faults show up at the ports within a couple of edges. A wrong burst counter or a wrong order choice returns the word from a neighbouring location on the second or later beat. A stale run flag makes the bus keep driving, or stay silent, one edge after a deselect or a wake from standby. A wrong lane mask is hidden until the word is read back, which is the next read of that address. So every write pattern is read back in full, and the bench compares the bus state on every edge against a behavioural model.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

   // kind of array access decided for the current edge
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

   // width of the internal burst counter
   localparam int BURST_W = 2;

   // low address bits of a burst beat for the selected order
   function automatic logic [BURST_W-1:0] burst_low(
      input logic [BURST_W-1:0] start,
      input logic [BURST_W-1:0] count,
      input logic               linear
   );
      return linear ? (start + count) : (start ^ count);
   endfunction

endpackage

// File: rtl/sbr_burst_seq.sv
module sbr_burst_seq
   import sbr_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0]  base,
   input  logic [BURST_W-1:0] count,
   input  logic               linear,
   output logic [ADDR_W-1:0]  beat_addr
);

   // upper bits are frozen for the whole burst, low bits are sequenced
   assign beat_addr = {base[ADDR_W-1:BURST_W], burst_low(base[BURST_W-1:0], count, linear)};

endmodule

// File: rtl/sbr_access_ctrl.sv
module sbr_access_ctrl
   import sbr_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              sleep,
   input  logic              en_a_n,
   input  logic              en_b,
   input  logic              en_c_n,
   input  logic              strb_cpu_n,
   input  logic              strb_ctl_n,
   input  logic              step_n,
   input  logic              seq_linear,
   input  logic              wr_all_n,
   input  logic [LANES-1:0]  wr_lane_n,
   input  logic [ADDR_W-1:0] addr,
   output acc_e              acc_kind,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [LANES-1:0]  acc_mask
);

   logic [ADDR_W-1:0]  base_r;
   logic [BURST_W-1:0] cnt_r;
   logic               run_r;

   logic               chip_sel;
   logic               cpu_go;
   logic               ctl_go;
   logic               wr_any;
   logic               load;
   logic               drop;
   logic [BURST_W-1:0] cnt_adv;
   logic [BURST_W-1:0] cnt_use;
   logic [ADDR_W-1:0]  base_use;

   assign chip_sel = !en_a_n && en_b && !en_c_n;
   assign cpu_go   = !strb_cpu_n && !en_a_n;
   assign ctl_go   = !strb_ctl_n && !cpu_go;
   assign wr_any   = !wr_all_n || !(&wr_lane_n);
   assign acc_mask = wr_all_n ? ~wr_lane_n : {LANES{1'b1}};
   assign cnt_adv  = step_n ? cnt_r : cnt_r + BURST_W'(1);

   always_comb begin
      acc_kind = ACC_NONE;
      load     = 1'b0;
      drop     = 1'b0;
      if (sleep) begin
         drop = 1'b1;
      end else if (cpu_go || ctl_go) begin
         if (chip_sel) begin
            load     = 1'b1;
            acc_kind = (ctl_go && wr_any) ? ACC_WRITE : ACC_READ;
         end else begin
            drop = 1'b1;
         end
      end else if (run_r) begin
         acc_kind = wr_any ? ACC_WRITE : ACC_READ;
      end
   end

   assign base_use = load ? addr : base_r;
   assign cnt_use  = load ? '0 : cnt_adv;

   sbr_burst_seq #(
      .ADDR_W (ADDR_W)
   ) u_seq (
      .base      (base_use),
      .count     (cnt_use),
      .linear    (seq_linear),
      .beat_addr (acc_addr)
   );

   always_ff @(posedge clk) begin
      if (load) begin
         base_r <= addr;
         cnt_r  <= '0;
         run_r  <= 1'b1;
      end else if (drop) begin
         run_r  <= 1'b0;
      end else if (run_r) begin
         cnt_r  <= cnt_adv;
      end
   end

endmodule

// File: rtl/sbr_lane_array.sv
module sbr_lane_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES-1:0]        wr_mask,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [LANES*LANE_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && wr_mask[g]) begin
            cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
         end
      end

      assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
   end

endmodule

// File: rtl/sbr_read_pipe.sv
module sbr_read_pipe #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              sleep,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] stage_addr,
   output logic              stage_v,
   input  logic [DATA_W-1:0] arr_data,
   input  logic              out_en_n,
   output logic              out_held,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_on
);

   logic [DATA_W-1:0] q_r;

   // stage one holds the read address, stage two the word for the bus
   always_ff @(posedge clk) begin
      if (sleep) begin
         stage_v  <= 1'b0;
         out_held <= 1'b0;
      end else begin
         stage_v  <= rd_req;
         out_held <= stage_v;
         if (rd_req) begin
            stage_addr <= rd_addr;
         end
         if (stage_v) begin
            q_r <= arr_data;
         end
      end
   end

   assign rdata_on = out_held && !out_en_n && !sleep;
   assign rdata    = rdata_on ? q_r : {DATA_W{1'bz}};

endmodule

// File: rtl/sync_burst_ram.sv
module sync_burst_ram
   import sbr_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 36,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              sleep,
   input  logic              en_a_n,
   input  logic              en_b,
   input  logic              en_c_n,
   input  logic              strb_cpu_n,
   input  logic              strb_ctl_n,
   input  logic              step_n,
   input  logic              seq_linear,
   input  logic              wr_all_n,
   input  logic [LANES-1:0]  wr_lane_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              out_en_n,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_on
);

   localparam int LANE_W = DATA_W / LANES;

   if (LANES < 1 || (DATA_W % LANES) != 0) begin : g_bad_lanes
      $error("sync_burst_ram: DATA_W must split evenly into LANES");
   end
   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("sync_burst_ram: ADDR_W must exceed the burst counter width");
   end

   acc_e              acc_kind;
   logic [ADDR_W-1:0] acc_addr;
   logic [LANES-1:0]  acc_mask;
   logic [ADDR_W-1:0] rd_stage_addr;
   logic              rd_stage_v;
   logic              out_held;
   logic [DATA_W-1:0] arr_rdata;

   sbr_access_ctrl #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES)
   ) u_ctrl (
      .clk        (clk),
      .sleep      (sleep),
      .en_a_n     (en_a_n),
      .en_b       (en_b),
      .en_c_n     (en_c_n),
      .strb_cpu_n (strb_cpu_n),
      .strb_ctl_n (strb_ctl_n),
      .step_n     (step_n),
      .seq_linear (seq_linear),
      .wr_all_n   (wr_all_n),
      .wr_lane_n  (wr_lane_n),
      .addr       (addr),
      .acc_kind   (acc_kind),
      .acc_addr   (acc_addr),
      .acc_mask   (acc_mask)
   );

   sbr_lane_array #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_array (
      .clk     (clk),
      .wr_en   (acc_kind == ACC_WRITE),
      .wr_addr (acc_addr),
      .wr_mask (acc_mask),
      .wr_data (wdata),
      .rd_addr (rd_stage_addr),
      .rd_data (arr_rdata)
   );

   sbr_read_pipe #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_pipe (
      .clk        (clk),
      .sleep      (sleep),
      .rd_req     (acc_kind == ACC_READ),
      .rd_addr    (acc_addr),
      .stage_addr (rd_stage_addr),
      .stage_v    (rd_stage_v),
      .arr_data   (arr_rdata),
      .out_en_n   (out_en_n),
      .out_held   (out_held),
      .rdata      (rdata),
      .rdata_on   (rdata_on)
   );

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker
   import sbr_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              sleep,
   input logic              en_a_n,
   input logic              en_b,
   input logic              en_c_n,
   input logic              strb_cpu_n,
   input logic              strb_ctl_n,
   input logic              step_n,
   input logic              seq_linear,
   input logic              out_en_n,
   input acc_e              acc_kind,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              s1_valid,
   input logic              out_on,
   input logic              rdata_on
);

   logic primed = 1'b0;
   always_ff @(posedge clk) begin
      if (sleep) primed <= 1'b1;
   end

   logic cpu_take;
   logic any_start;
   logic cont;
   logic desel_start;
   assign cpu_take    = !strb_cpu_n && !en_a_n;
   assign any_start   = cpu_take || !strb_ctl_n;
   assign cont        = !any_start;
   assign desel_start = any_start && !(!en_a_n && en_b && !en_c_n);

   // R1 / R9: a deselecting start releases the bus one edge later
   a_r1_desel_release: assert property (@(posedge clk) disable iff (sleep || !primed)
      $past(desel_start) |=> !rdata_on);

   // R3: a processor start never writes
   a_r3_cpu_is_read: assert property (@(posedge clk) disable iff (sleep || !primed)
      cpu_take |-> acc_kind != ACC_WRITE);

   // R4: without advance the beat address repeats
   a_r4_hold_addr: assert property (@(posedge clk) disable iff (sleep || !primed)
      (cont && acc_kind != ACC_NONE && step_n) |-> acc_addr == $past(acc_addr));

   // R5: linear advance adds one to the low bits, upper bits fixed
   a_r5_linear_step: assert property (@(posedge clk) disable iff (sleep || !primed)
      (cont && acc_kind != ACC_NONE && !step_n && seq_linear && $past(seq_linear))
      |-> (acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1)
          && (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])));

   // R8: a registered read reaches the output stage on the next edge
   a_r8_read_latency: assert property (@(posedge clk) disable iff (sleep || !primed)
      s1_valid |=> out_on);

   // R10: output enable high means the bus is not driven
   a_r10_oe_gate: assert property (@(posedge clk) disable iff (sleep || !primed)
      out_en_n |-> !rdata_on);

   // R11: standby empties the read pipeline
   a_r11_sleep_clears: assert property (@(posedge clk) disable iff (!primed)
      sleep |=> (!out_on && !s1_valid));

endmodule

bind sync_burst_ram sbr_checker #(
   .ADDR_W (ADDR_W)
) u_sbr_checker (
   .clk        (clk),
   .sleep      (sleep),
   .en_a_n     (en_a_n),
   .en_b       (en_b),
   .en_c_n     (en_c_n),
   .strb_cpu_n (strb_cpu_n),
   .strb_ctl_n (strb_ctl_n),
   .step_n     (step_n),
   .seq_linear (seq_linear),
   .out_en_n   (out_en_n),
   .acc_kind   (acc_kind),
   .acc_addr   (acc_addr),
   .s1_valid   (rd_stage_v),
   .out_on     (out_held),
   .rdata_on   (rdata_on)
);

// File: tb/test_sync_burst_ram.sv
`timescale 1ns/100ps
module test_sync_burst_ram;

   localparam int AW = 6;
   localparam int DW = 36;
   localparam int NL = 4;
   localparam int LW = DW / NL;

   logic          clk = 1'b0;
   logic          sleep = 1'b1;
   logic          en_a_n = 1'b1, en_b = 1'b0, en_c_n = 1'b1;
   logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, step_n = 1'b1;
   logic          seq_linear = 1'b1;
   logic          wr_all_n = 1'b1;
   logic [NL-1:0] wr_lane_n = '1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          out_en_n = 1'b0;
   logic [DW-1:0] rdata;
   logic          rdata_on;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sync_burst_ram #(.ADDR_W(AW), .DATA_W(DW), .LANES(NL)) i_sync_burst_ram (
      .clk(clk), .sleep(sleep), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
      .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
      .seq_linear(seq_linear), .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n),
      .addr(addr), .wdata(wdata), .out_en_n(out_en_n),
      .rdata(rdata), .rdata_on(rdata_on)
   );

   // behavioural reference state
   logic [DW-1:0] m_mem [0:(1<<AW)-1];
   bit            m_run = 0;
   int            m_base = 0;
   int            m_cnt = 0;
   bit            m_v1 = 0;
   logic [DW-1:0] m_d1 = '0;
   bit            m_drv = 0;
   logic [DW-1:0] m_q = '0;

   function automatic logic [DW-1:0] pat(input int n);
      return {4'(n), 32'(n) * 32'h9E37_79B1};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_edge();
      bit cpu, ctl, sel, wr, acc, w;
      int lo, a;
      logic [NL-1:0] mask;
      if (sleep) begin
         m_run = 0; m_v1 = 0; m_drv = 0;
         return;
      end
      m_drv = m_v1;
      m_q   = m_d1;
      cpu  = !strb_cpu_n && !en_a_n;
      ctl  = !strb_ctl_n && !cpu;
      sel  = !en_a_n && en_b && !en_c_n;
      wr   = !wr_all_n || (wr_lane_n != '1);
      mask = wr_all_n ? ~wr_lane_n : '1;
      acc  = 0;
      w    = 0;
      if (cpu || ctl) begin
         if (sel) begin
            m_base = int'(addr); m_cnt = 0; m_run = 1; acc = 1; w = ctl && wr;
         end else begin
            m_run = 0;
         end
      end else if (m_run) begin
         if (!step_n) m_cnt = (m_cnt + 1) % 4;
         acc = 1; w = wr;
      end
      lo = seq_linear ? ((m_base % 4) + m_cnt) % 4 : ((m_base % 4) ^ m_cnt);
      a  = (m_base / 4) * 4 + lo;
      if (acc && w) begin
         for (int i = 0; i < NL; i++)
            if (mask[i]) m_mem[a][i*LW +: LW] = wdata[i*LW +: LW];
      end
      m_v1 = acc && !w;
      if (m_v1) m_d1 = m_mem[a];
   endtask

   // one clock: model follows the edge, outputs compared 1 ns later
   task automatic step(input string tag);
      bit exp_on;
      @(posedge clk);
      model_edge();
      #1;
      exp_on = m_drv && !out_en_n && !sleep;
      check(rdata_on == exp_on, {tag, " rdata_on"}, DW'(rdata_on), DW'(exp_on));
      if (exp_on) check(rdata === m_q, {tag, " rdata"}, rdata, m_q);
      @(negedge clk);
   endtask

   task automatic quiet();
      strb_cpu_n = 1; strb_ctl_n = 1; step_n = 1; wr_all_n = 1; wr_lane_n = '1;
   endtask

   task automatic select_all();
      en_a_n = 0; en_b = 1; en_c_n = 0;
   endtask

   task automatic ctl_start(input int a, input bit do_wr, input int n);
      strb_ctl_n = 0; strb_cpu_n = 1; addr = AW'(a); step_n = 1;
      wr_all_n = !do_wr; wr_lane_n = '1; wdata = pat(n);
   endtask

   task automatic deselect(input string tag);
      quiet(); en_b = 0; strb_ctl_n = 0; step(tag);
      quiet(); select_all(); step(tag); step(tag);
   endtask

   initial begin
      for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
      @(negedge clk);
      // R11: standby after power-up, bus quiet
      repeat (3) step("R11 reset");
      sleep = 0; select_all(); quiet();
      step("R9 idle");

      // R2 R5 R7: linear write burst from 0x0A with global write
      seq_linear = 1;
      ctl_start(6'h0A, 1, 1); step("R2 write start");
      for (int k = 2; k <= 4; k++) begin
         strb_ctl_n = 1; step_n = 0; wdata = pat(k); step("R5 write beat");
      end
      // R8 R5: linear read back
      ctl_start(6'h0A, 0, 0); step("R8 read start");
      for (int k = 0; k < 3; k++) begin
         strb_ctl_n = 1; step_n = 0; step("R5 read beat");
      end
      deselect("R9 release");

      // R6: interleaved write and read from 0x0E
      seq_linear = 0;
      ctl_start(6'h0E, 1, 5); step("R6 write start");
      for (int k = 6; k <= 8; k++) begin
         strb_ctl_n = 1; step_n = 0; wdata = pat(k); step("R6 write beat");
      end
      ctl_start(6'h0E, 0, 0); step("R6 read start");
      for (int k = 0; k < 3; k++) begin
         strb_ctl_n = 1; step_n = 0; step("R6 read beat");
      end
      deselect("R9 release");
      // same locations read in linear order from 0x0C
      seq_linear = 1;
      ctl_start(6'h0C, 0, 0); step("R6 cross read");
      for (int k = 0; k < 3; k++) begin
         strb_ctl_n = 1; step_n = 0; step("R6 cross beat");
      end
      deselect("R9 release");

      // R7: lane writes, then global write overriding lane enables
      ctl_start(6'h0A, 0, 0); wr_lane_n = 4'b1010; wr_all_n = 1; wdata = pat(9);
      step("R7 lanes 0 and 2");
      strb_ctl_n = 1; wr_lane_n = 4'b0111; wdata = pat(12); step("R7 lane 3");
      quiet(); step("R7 read same beat");
      step("R7 read again");
      ctl_start(6'h0B, 1, 13); wr_lane_n = 4'b0111; step("R7 global");
      quiet(); step("R7 read global");
      ctl_start(6'h0A, 0, 0); step("R7 readback");
      strb_ctl_n = 1; step_n = 0; step("R7 readback beat");
      deselect("R9 release");

      // R3: processor start ignores write controls, next cycle writes
      strb_cpu_n = 0; addr = 6'h09; wr_all_n = 0; wdata = pat(20); step("R3 cpu read");
      strb_cpu_n = 1; step("R3 follow-on write");
      quiet(); step("R3 read after write");
      // R3: both strobes low, processor wins and reads
      strb_cpu_n = 0; strb_ctl_n = 0; addr = 6'h08; wr_all_n = 0; wdata = pat(21);
      step("R3 priority");
      quiet(); step("R3 priority read");
      // R3: processor strobe ignored with en_a_n high, burst continues
      en_a_n = 1; strb_cpu_n = 0; step_n = 0; step("R3 cpu ignored");
      step("R3 cpu ignored 2");
      select_all(); quiet(); step("R4 hold");
      // R4: enables false during continuation are ignored
      en_b = 0; en_c_n = 1; step("R4 enables ignored");
      step("R4 enables ignored 2");
      select_all(); deselect("R1 deselect");

      // R1: each enable alone deselects a start
      en_a_n = 1; strb_ctl_n = 0; addr = 6'h08; step("R1 en_a_n");
      quiet(); step("R1 en_a_n"); step("R1 en_a_n");
      select_all(); en_c_n = 1; strb_ctl_n = 0; step("R1 en_c_n");
      quiet(); select_all(); step("R1 en_c_n"); step("R1 en_c_n");

      // R10: output enable acts between edges
      ctl_start(6'h0A, 0, 0); step("R10 read");
      quiet(); step("R10 driven");
      out_en_n = 1; #0.5;
      check(rdata_on == 1'b0, "R10 oe high", DW'(rdata_on), DW'(0));
      out_en_n = 0; #0.5;
      check(rdata_on == 1'b1, "R10 oe low", DW'(rdata_on), DW'(1));
      check(rdata === m_q, "R10 same word", rdata, m_q);

      // R11: standby mid-burst ignores a write and ends the burst
      sleep = 1; #0.5;
      check(rdata_on == 1'b0, "R11 sleep async", DW'(rdata_on), DW'(0));
      ctl_start(6'h0A, 1, 30); step("R11 write ignored");
      step("R11 write ignored 2");
      sleep = 0; quiet(); step("R11 burst ended");
      step("R11 burst ended 2");
      ctl_start(6'h0A, 0, 0); step("R11 contents kept");
      quiet(); step("R11 contents kept 2");
      deselect("R9 release");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule